// File: doc/BRIEF.md
# Daisy-Chain Serial Converter Host Controller

This block drives a chain of serial digital-to-analog converters from one system clock. The chain is loaded through three outputs: an active-low frame select, a serial clock and a serial data line. Each converter in the chain takes an 18-bit word. For every device the user supplies a write enable, a 4-bit channel address and a 12-bit code. The controller builds one frame of 18×N bits from these and shifts it out so that each word ends up in its own device. A device whose write enable is low receives a no-op word instead, so every device still sees exactly 18 clocks.

A transfer starts with a start/ready handshake, and the commands arrive as packed vectors. The controller lowers the frame select and waits a programmable setup time. It then toggles the serial clock with a programmable half-period and raises the frame select after the last bit, which commits the words in all devices. A one-cycle done pulse marks that moment. The controller then waits a minimum gap before it can accept another frame: one gap value applies to a single device and a longer one applies to a chain. It also watches the converters' active-low busy line. The clock is frozen while busy is low, and no new frame is accepted until busy is high.

Top module: `dac_chain_host`

## Requirements
- R1: After reset, sync_n and sclk are high, done is low, and ready is high whenever busy_n is high.
- R2: One frame holds sync_n low across exactly 18×N_DEV falling edges of sclk, and sclk is high when sync_n rises.
- R3: A device word is 18 bits, sent MSB first: mode[17:16], address[15:12], data[11:0]. A write uses mode code WRITE_MODE (default 2'b00), with address from addr_vec[4k+3:4k] and data from data_vec[12k+11:12k] for device k.
- R4: A device whose wr_en bit is 0 receives mode 2'b11 followed by 16 zero bits.
- R5: Device k is the k-th device counted from the host, starting at 0. The word for device N_DEV-1 is sent first and the word for device 0 is sent last.
- R6: The first falling edge of sclk comes exactly SETUP_CYC clock cycles after sync_n falls.
- R7: With busy_n high, each low phase of sclk lasts HALF_CYC clock cycles.
- R8: din changes only while sclk is high or on its rising edge, so it is stable through every low phase.
- R9: While busy_n is low, sclk does not change. The frame then resumes with no bit lost or repeated.
- R10: After sync_n rises, ready stays low for at least the gap time: GAP_SOLO_CYC cycles when N_DEV is 1, and GAP_CHAIN_CYC cycles otherwise. With busy_n high, it stays low for exactly that time.
- R11: ready is high only when the controller is idle and busy_n is high. A start pulse while ready is low is ignored.
- R12: done is a one-cycle pulse in the cycle where sync_n rises, once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; taken when ready is high |
| wr_en | input | N_DEV | Per-device write enable; 0 sends a no-op |
| addr_vec | input | 4×N_DEV | Per-device channel address, device k at [4k+3:4k] |
| data_vec | input | 12×N_DEV | Per-device code, device k at [12k+11:12k] |
| ready | output | 1 | Controller idle and converters not busy |
| busy_n | input | 1 | Converter busy, active low; synchronous to clk |
| sync_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data, changes on rising sclk |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
The main instance uses a three-device chain with HALF_CYC=2, SETUP_CYC=3 and GAP_CHAIN_CYC=8. These small values keep a 54-bit frame and its gap short, so write/no-op mixes, busy stalls in the middle of a frame and starts during the gap all fit in a short run. A second instance with N_DEV=1 and GAP_SOLO_CYC=4 covers the standalone case. In that case the gap choice and the 18-clock frame differ from the chain.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  localparam int MODE_W = 2;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 12;
  localparam int WORD_W = MODE_W + ADDR_W + DATA_W;
  localparam logic [MODE_W-1:0] NOP_MODE = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } host_state_e;
endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
  import dac_chain_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter logic [MODE_W-1:0] WRITE_MODE = 2'b00,
  localparam int FRAME_W = N_DEV * WORD_W
) (
  input  logic [N_DEV-1:0]        wr_en,
  input  logic [N_DEV*ADDR_W-1:0] addr_vec,
  input  logic [N_DEV*DATA_W-1:0] data_vec,
  output logic [FRAME_W-1:0]      frame
);
  // the farthest device occupies the top word, so it leaves first
  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    always_comb begin
      if (wr_en[k])
        frame[k*WORD_W +: WORD_W] = {WRITE_MODE, addr_vec[k*ADDR_W +: ADDR_W],
                                     data_vec[k*DATA_W +: DATA_W]};
      else
        frame[k*WORD_W +: WORD_W] = {NOP_MODE, {(ADDR_W+DATA_W){1'b0}}};
    end
  end
endmodule

// File: rtl/dac_timer.sv
module dac_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (en && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
  import dac_chain_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int HALF_CYC = 2,
  parameter int SETUP_CYC = 2,
  parameter int GAP_SOLO_CYC = 20,
  parameter int GAP_CHAIN_CYC = 40,
  parameter logic [1:0] WRITE_MODE = 2'b00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N_DEV-1:0]      wr_en,
  input  logic [N_DEV*4-1:0]    addr_vec,
  input  logic [N_DEV*12-1:0]   data_vec,
  output logic                  ready,
  input  logic                  busy_n,
  output logic                  sync_n,
  output logic                  sclk,
  output logic                  din,
  output logic                  done
);
  localparam int FRAME_W = N_DEV * WORD_W;
  localparam int GAP_CYC = (N_DEV == 1) ? GAP_SOLO_CYC : GAP_CHAIN_CYC;
  localparam int MAX_A   = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int MAX_CYC = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  host_state_e        state_q, state_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d, frame;
  logic [BIT_W-1:0]   bits_q, bits_d;
  logic               sync_q, sync_d, sclk_q, sclk_d, done_q, done_d;
  logic               tmr_load, tmr_en, tmr_zero;
  logic [CNT_W-1:0]   tmr_val;

  dac_frame_pack #(.N_DEV(N_DEV), .WRITE_MODE(WRITE_MODE)) i_pack (
    .wr_en(wr_en), .addr_vec(addr_vec), .data_vec(data_vec), .frame(frame)
  );

  dac_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .zero(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    shreg_d  = shreg_q;
    bits_d   = bits_q;
    sync_d   = sync_q;
    sclk_d   = sclk_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_en   = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && busy_n) begin
          shreg_d  = frame;
          bits_d   = BIT_W'(FRAME_W - 1);
          sync_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (busy_n) begin
          if (tmr_zero) begin
            sclk_d   = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HALF_CYC - 1);
            state_d  = ST_LOW;
          end else begin
            tmr_en = 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (busy_n) begin
          if (tmr_zero) begin
            sclk_d   = 1'b1;
            shreg_d  = {shreg_q[FRAME_W-2:0], 1'b0};
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HALF_CYC - 1);
            state_d  = ST_HIGH;
          end else begin
            tmr_en = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (busy_n) begin
          if (!tmr_zero) begin
            tmr_en = 1'b1;
          end else if (bits_q == '0) begin
            sync_d   = 1'b1;
            done_d   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(GAP_CYC - 1);
            state_d  = ST_GAP;
          end else begin
            bits_d   = bits_q - 1'b1;
            sclk_d   = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HALF_CYC - 1);
            state_d  = ST_LOW;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) state_d = ST_IDLE;
        else          tmr_en  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bits_q  <= '0;
      sync_q  <= 1'b1;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bits_q  <= bits_d;
      sync_q  <= sync_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
    end
  end

  assign ready  = (state_q == ST_IDLE) && busy_n;
  assign sync_n = sync_q;
  assign sclk   = sclk_q;
  assign din    = shreg_q[FRAME_W-1];
  assign done   = done_q;
endmodule

module dac_chain_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_n,
  input logic ready,
  input logic sync_n,
  input logic sclk,
  input logic din,
  input logic done
);
  p_sclk_high_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> sclk);
  p_sclk_high_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> sclk);
  p_din_steady_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(!sclk)) |-> $stable(din));
  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> $stable(sclk));
  p_ready_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (busy_n && sync_n));
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(sync_n));
endmodule

bind dac_chain_host dac_chain_host_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .ready(ready),
  .sync_n(sync_n), .sclk(sclk), .din(din), .done(done)
);

// File: tb/test_dac_chain_host.sv
module test_dac_chain_host;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 3;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int GAP_S = 4;
  localparam int GAP_C = 8;
  localparam int FW    = N * 18;

  typedef struct packed {
    logic [N-1:0]    we;
    logic [N*4-1:0]  ad;
    logic [N*12-1:0] dt;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{we: 3'b111, ad: 12'h3A5, dt: 36'hFFF_000_A5C},
    '{we: 3'b000, ad: 12'hFFF, dt: 36'h123_456_789},
    '{we: 3'b101, ad: 12'hC07, dt: 36'h800_FFF_001},
    '{we: 3'b010, ad: 12'h0E0, dt: 36'h000_7E1_000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, busy_n = 1'b1;
  logic [N-1:0] wr_en = '0;
  logic [N*4-1:0] addr_vec = '0;
  logic [N*12-1:0] data_vec = '0;
  logic ready, sync_n, sclk, din, done;

  logic start_s = 1'b0;
  logic ready_s, sync_s, sclk_s, din_s, done_s;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_host #(.N_DEV(N), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
    .GAP_SOLO_CYC(GAP_S), .GAP_CHAIN_CYC(GAP_C), .WRITE_MODE(2'b00)) i_dac_chain_host (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr_vec(addr_vec),
    .data_vec(data_vec), .ready(ready), .busy_n(busy_n), .sync_n(sync_n),
    .sclk(sclk), .din(din), .done(done));

  dac_chain_host #(.N_DEV(1), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
    .GAP_SOLO_CYC(GAP_S), .GAP_CHAIN_CYC(GAP_C), .WRITE_MODE(2'b00)) i_dac_chain_host_solo (
    .clk(clk), .rst_n(rst_n), .start(start_s), .wr_en(1'b1), .addr_vec(4'h9),
    .data_vec(12'hABC), .ready(ready_s), .busy_n(1'b1), .sync_n(sync_s),
    .sclk(sclk_s), .din(din_s), .done(done_s));

  // observers for the chain instance
  logic sclk_q = 1'b1, sync_q = 1'b1;
  logic [FW-1:0] cap = '0;
  int nfall = 0, su_cnt = 0, low_cnt = 0, low_bad = 0, done_cnt = 0, gap_cnt = 0;
  bit gap_run = 0;

  always @(negedge clk) begin
    if (!sync_n) begin
      if (sclk_q && !sclk) begin cap = {cap[FW-2:0], din}; nfall++; end
      if (nfall == 0 && sclk) su_cnt++;
      if (!sclk) low_cnt++;
      if (!sclk_q && sclk) begin if (low_cnt != HALF) low_bad++; low_cnt = 0; end
      gap_run = 0;
    end
    if (done) done_cnt++;
    if (sync_n && !sync_q) gap_run = 1;
    if (gap_run) begin if (ready) gap_run = 0; else gap_cnt++; end
    sclk_q = sclk;
    sync_q = sync_n;
  end

  // observers for the standalone instance
  logic ssclk_q = 1'b1, ssync_q = 1'b1;
  logic [17:0] s_cap = '0;
  int s_nfall = 0, s_gap = 0;
  bit s_run = 0;

  always @(negedge clk) begin
    if (!sync_s && ssclk_q && !sclk_s) begin s_cap = {s_cap[16:0], din_s}; s_nfall++; end
    if (sync_s && !ssync_q) s_run = 1;
    if (s_run) begin if (ready_s) s_run = 0; else s_gap++; end
    ssclk_q = sclk_s;
    ssync_q = sync_s;
  end

  function automatic logic [FW-1:0] exp_frame(vec_t v);
    logic [FW-1:0] r;
    for (int k = 0; k < N; k++)
      r[k*18 +: 18] = v.we[k] ? {2'b00, v.ad[k*4 +: 4], v.dt[k*12 +: 12]}
                              : {2'b11, 16'h0000};
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    while (!ready) @(negedge clk);
    cap = '0; nfall = 0; su_cnt = 0; low_cnt = 0; low_bad = 0; done_cnt = 0; gap_cnt = 0;
    wr_en = v.we; addr_vec = v.ad; data_vec = v.dt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input vec_t v);
    launch(v);
    while (done_cnt == 0) @(negedge clk);
    repeat (GAP_C + 3) @(negedge clk);
    chk("R3 R4 R5 frame bits", 64'(cap), 64'(exp_frame(v)));
    chk("R2 falling edges", 64'(nfall), 64'(FW));
    chk("R6 setup cycles", 64'(su_cnt), 64'(SETUP));
    chk("R7 low phases off", 64'(low_bad), 64'd0);
    chk("R12 done pulses", 64'(done_cnt), 64'd1);
    chk("R10 chain gap", 64'(gap_cnt), 64'(GAP_C));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic s0;
    int stall_bad, nf0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sync_n", 64'(sync_n), 64'd1);
    chk("R1 sclk", 64'(sclk), 64'd1);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 ready", 64'(ready), 64'd1);

    foreach (TBL[i]) run_frame(TBL[i]);

    // R9: busy stall in mid-frame
    launch(TBL[2]);
    while (nfall < 20) @(negedge clk);
    busy_n = 1'b0;
    s0 = sclk; nf0 = nfall; stall_bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (sclk !== s0) stall_bad++;
    end
    chk("R9 sclk frozen", 64'(stall_bad), 64'd0);
    chk("R9 no edges while busy", 64'(nfall), 64'(nf0));
    busy_n = 1'b1;
    while (done_cnt == 0) @(negedge clk);
    chk("R9 frame intact", 64'(cap), 64'(exp_frame(TBL[2])));
    chk("R9 edge count", 64'(nfall), 64'(FW));

    // R11: busy held low after the frame blocks ready and start
    busy_n = 1'b0;
    repeat (GAP_C + 6) @(negedge clk);
    chk("R11 ready low while busy", 64'(ready), 64'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 start ignored", 64'(sync_n), 64'd1);
    busy_n = 1'b1;
    @(negedge clk);
    chk("R11 ready returns", 64'(ready), 64'd1);

    // standalone instance: 18-bit frame and short gap
    start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    while (!done_s) @(negedge clk);
    repeat (GAP_S + 3) @(negedge clk);
    chk("R2 solo edges", 64'(s_nfall), 64'd18);
    chk("R3 solo word", 64'(s_cap), 64'({2'b00, 4'h9, 12'hABC}));
    chk("R10 solo gap", 64'(s_gap), 64'(GAP_S));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule